// File: doc/BRIEF.md
# Bit-Serial Laplacian Pixel Element

This block is the processing element for one pixel of a mesh-connected image array. It holds its own 8-bit grayscale pixel in a small shift register. On each pass it streams that pixel out least significant bit first, so the four neighbouring elements can use it. At the same time it takes in four serial streams from its north, south, east and west neighbours. It returns the four-neighbour Laplacian: the centre pixel minus one quarter of the neighbour sum.

All arithmetic runs one bit per clock. Each operation uses a single full adder whose carry is held in a flip-flop. Three such stages add the neighbours. The quarter is taken by ignoring the two lowest sum bits, which is done by delaying the centre stream by two clocks. A fourth stage subtracts by adding the inverted quarter bits with its carry preset to one. The 10-bit two's-complement result is shifted, LSB first, into a result register.

One level control is shared by the whole array. While it is low, every element is cleared and can be loaded in parallel. Raising it starts a pass, which lasts a fixed twelve clocks.

Top module: `lap_cell`

## Requirements
- R1: After reset, `result`, `pix_q`, `pix_bit` and `done` are all zero.
- R2: While `run` is low, a clock edge with `load_en` high copies `load_pix` into the pixel register, which is visible on `pix_q` after that edge.
- R3: A pass starts at the first rising edge with `run` high, counted as edge 0. At edge k the neighbour inputs must carry bit k of their neighbour's pixel for k = 0..7 and zero for k = 8..11.
- R4: During a pass, `pix_bit` shows bit k of the stored pixel in the cycle before edge k for k = 0..7. It is zero in every other cycle. After the pass `pix_q` again holds the original pixel.
- R5: `done` is high for exactly one cycle per completed pass, namely the cycle after edge 11, and the full result is valid from that cycle on.
- R6: `result` equals centre − floor((N+S+E+W)/4) as a 10-bit two's-complement value, and always lies in −255..255.
- R7: Because the quarter is truncated, 4·result − (4·centre − (N+S+E+W)) is always in 0..3.
- R8: `load_en` has no effect while `run` is high, including at the edge where the pass starts.
- R9: Dropping `run` before edge 11 abandons the pass without a `done` pulse and clears all carries, so the next pass is exact.
- R10: After `done`, `result` holds its value until the next pass writes it, whether `run` stays high or falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Shared compute (high) / clear (low) control |
| load_en | input | 1 | Parallel pixel load strobe, honoured only while run is low |
| load_pix | input | 8 | Pixel value to load |
| nb_n | input | 1 | Serial pixel stream from the north neighbour, LSB first |
| nb_s | input | 1 | Serial pixel stream from the south neighbour, LSB first |
| nb_e | input | 1 | Serial pixel stream from the east neighbour, LSB first |
| nb_w | input | 1 | Serial pixel stream from the west neighbour, LSB first |
| pix_bit | output | 1 | Own pixel streamed LSB first to the neighbours |
| pix_q | output | 8 | Parallel readout of the pixel register |
| result | output | 10 | Signed Laplacian result |
| done | output | 1 | One-cycle pulse when the last result bit is written |

## Verification
Two functions can land on the same clock edge: a parallel load request and the start of a pass. The bench provokes this by holding `load_en` high, with the inverted pixel on `load_pix`, on the very edge where `run` rises and throughout the pass. It then judges the outcome in two ways. The streamed pixel bits must match the original value. When `done` pulses, `pix_q` must again show the original pixel and the result must match one computed from it. A second overlap occurs when `run` falls in the middle of a pass. The pass that follows must produce an exact value, and no stray `done` may appear.

// File: rtl/lap_pkg.sv
package lap_pkg;

  // control decoded from the pass counter
  typedef struct packed {
    logic clr;      // clear carries and delay line
    logic en_sum;   // bit slot inside the pass
    logic cen_take; // own pixel still streaming
    logic write;    // result bit is produced this slot
    logic last;     // final result bit slot
  } lap_ctl_t;

  function automatic logic fa_sum(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

  function automatic logic fa_cy(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/lap_bsadd.sv
module lap_bsadd #(
  parameter bit CY_INIT = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic a,
  input  logic b,
  output logic s,
  output logic cy_q
);
  import lap_pkg::*;

  assign s = fa_sum(a, b, cy_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cy_q <= CY_INIT;
    else if (clr) cy_q <= CY_INIT;
    else if (en)  cy_q <= fa_cy(a, b, cy_q);
  end
endmodule

// File: rtl/lap_seq.sv
module lap_seq #(
  parameter int PIX_W = 8,
  parameter int RES_W = 10,
  parameter int DROP  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  output lap_pkg::lap_ctl_t  ctl,
  output logic               done
);
  localparam int PASS = RES_W + DROP;
  localparam int CW   = $clog2(PASS + 1);

  logic [CW-1:0] cnt;
  logic          busy;

  assign busy         = run && (cnt < CW'(PASS));
  assign ctl.clr      = !run;
  assign ctl.en_sum   = busy;
  assign ctl.cen_take = busy && (cnt < CW'(PIX_W));
  assign ctl.write    = busy && (cnt >= CW'(DROP));
  assign ctl.last     = busy && (cnt == CW'(PASS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= ctl.last;
      if (!run)      cnt <= '0;
      else if (busy) cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/lap_pixreg.sv
module lap_pixreg #(
  parameter int PIX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             rot,
  input  logic             load_en,
  input  logic [PIX_W-1:0] load_val,
  output logic [PIX_W-1:0] pix_q,
  output logic             ser_bit
);
  // rotating so the stored value is back in place after PIX_W shifts
  assign ser_bit = rot & pix_q[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pix_q <= '0;
    else if (rot)              pix_q <= {pix_q[0], pix_q[PIX_W-1:1]};
    else if (!run && load_en)  pix_q <= load_val;
  end
endmodule

// File: rtl/lap_cell.sv
module lap_cell #(
  parameter int PIX_W = 8,
  parameter int RES_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             load_en,
  input  logic [PIX_W-1:0] load_pix,
  input  logic             nb_n,
  input  logic             nb_s,
  input  logic             nb_e,
  input  logic             nb_w,
  output logic             pix_bit,
  output logic [PIX_W-1:0] pix_q,
  output logic [RES_W-1:0] result,
  output logic             done
);
  import lap_pkg::*;

  localparam int DROP = 2;  // quarter = discard two low sum bits

  lap_ctl_t ctl;
  logic [3:0] nb_vec;
  logic [1:0] pair_bit;
  logic [1:0] pair_cy;
  logic       quad_bit;
  logic       quad_cy;
  logic       diff_bit;
  logic       diff_cy;
  logic [DROP-1:0] cen_dly;

  assign nb_vec = {nb_w, nb_e, nb_s, nb_n};

  lap_seq #(.PIX_W(PIX_W), .RES_W(RES_W), .DROP(DROP)) u_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .ctl(ctl), .done(done)
  );

  lap_pixreg #(.PIX_W(PIX_W)) u_pix (
    .clk(clk), .rst_n(rst_n), .run(run), .rot(ctl.cen_take),
    .load_en(load_en), .load_val(load_pix), .pix_q(pix_q), .ser_bit(pix_bit)
  );

  // first level: north+south, east+west
  for (genvar g = 0; g < 2; g++) begin : g_pair
    lap_bsadd #(.CY_INIT(1'b0)) u_add (
      .clk(clk), .rst_n(rst_n), .clr(ctl.clr), .en(ctl.en_sum),
      .a(nb_vec[2*g]), .b(nb_vec[2*g+1]), .s(pair_bit[g]), .cy_q(pair_cy[g])
    );
  end

  lap_bsadd #(.CY_INIT(1'b0)) u_quad (
    .clk(clk), .rst_n(rst_n), .clr(ctl.clr), .en(ctl.en_sum),
    .a(pair_bit[0]), .b(pair_bit[1]), .s(quad_bit), .cy_q(quad_cy)
  );

  // centre delayed by DROP slots so it lines up with sum bit k+DROP
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cen_dly <= '0;
    else if (ctl.clr)    cen_dly <= '0;
    else if (ctl.en_sum) cen_dly <= {cen_dly[DROP-2:0], pix_bit};
  end

  // subtract: centre + ~quarter + 1
  lap_bsadd #(.CY_INIT(1'b1)) u_sub (
    .clk(clk), .rst_n(rst_n), .clr(ctl.clr), .en(ctl.write),
    .a(cen_dly[DROP-1]), .b(~quad_bit), .s(diff_bit), .cy_q(diff_cy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         result <= '0;
    else if (ctl.write) result <= {diff_bit, result[RES_W-1:1]};
  end
endmodule

// File: rtl/lap_cell_chk.sv
module lap_cell_chk #(
  parameter int PIX_W = 8,
  parameter int RES_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             load_en,
  input logic [PIX_W-1:0] load_pix,
  input logic             pix_bit,
  input logic [PIX_W-1:0] pix_q,
  input logic [RES_W-1:0] result,
  input logic             done
);
  localparam int LIM = (1 << PIX_W) - 1;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && load_en) |=> (pix_q == $past(load_pix)));

  p_idle_stream_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !pix_bit);

  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (($signed(result) >= -LIM) && ($signed(result) <= LIM)));

  p_no_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !done);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> $stable(result));
endmodule

bind lap_cell lap_cell_chk #(.PIX_W(PIX_W), .RES_W(RES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .load_en(load_en), .load_pix(load_pix),
  .pix_bit(pix_bit), .pix_q(pix_q), .result(result), .done(done)
);

// File: tb/lap_cell_tb_top.sv
module lap_cell_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PIX_W = 8;
  localparam int RES_W = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic load_en = 1'b0;
  logic [PIX_W-1:0] load_pix = '0;
  logic nb_n = 1'b0, nb_s = 1'b0, nb_e = 1'b0, nb_w = 1'b0;
  logic pix_bit;
  logic [PIX_W-1:0] pix_q;
  logic [RES_W-1:0] result;
  logic done;

  typedef struct {
    int c;
    int sum;
    int exp_v;
  } item_t;

  item_t sb[$];
  item_t cur;
  int checks = 0;
  int fails = 0;
  int r_mon;

  always #(CLK_PERIOD/2) clk = ~clk;

  lap_cell #(.PIX_W(PIX_W), .RES_W(RES_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .run(run), .load_en(load_en), .load_pix(load_pix),
    .nb_n(nb_n), .nb_s(nb_s), .nb_e(nb_e), .nb_w(nb_w),
    .pix_bit(pix_bit), .pix_q(pix_q), .result(result), .done(done)
  );

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int as_signed(input logic [RES_W-1:0] v);
    return v[RES_W-1] ? int'(v) - (1 << RES_W) : int'(v);
  endfunction

  // monitor: pops an expected item at every done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9 done without a completed pass", 1, 0);
      end else begin
        cur = sb.pop_front();
        r_mon = as_signed(result);
        chk(r_mon == cur.exp_v, "R6 result", r_mon, cur.exp_v);
        chk((4*r_mon - (4*cur.c - cur.sum)) >= 0 && (4*r_mon - (4*cur.c - cur.sum)) <= 3,
            "R7 truncation bound", 4*r_mon - (4*cur.c - cur.sum), 0);
        chk(int'(pix_q) == cur.c, "R4/R8 pixel restored", int'(pix_q), cur.c);
      end
    end
  end

  task automatic run_pass(input logic [7:0] c, input logic [7:0] n, input logic [7:0] s,
                          input logic [7:0] e, input logic [7:0] w, input bit clash);
    item_t it;
    logic [RES_W-1:0] held;
    @(negedge clk);
    run = 1'b0; load_en = 1'b1; load_pix = c;
    @(negedge clk);
    load_en = 1'b0;
    chk(pix_q == c, "R2 parallel load", int'(pix_q), int'(c));
    it.c = int'(c);
    it.sum = int'(n) + int'(s) + int'(e) + int'(w);
    it.exp_v = it.c - it.sum / 4;
    sb.push_back(it);
    run = 1'b1;
    if (clash) begin
      load_en = 1'b1; load_pix = ~c;   // R8: load request on the start edge and after
    end
    for (int k = 0; k < 12; k++) begin
      if (k > 0) @(negedge clk);
      nb_n = (k < 8) ? n[k[2:0]] : 1'b0;
      nb_s = (k < 8) ? s[k[2:0]] : 1'b0;
      nb_e = (k < 8) ? e[k[2:0]] : 1'b0;
      nb_w = (k < 8) ? w[k[2:0]] : 1'b0;
      #1;
      if (k < 8) chk(pix_bit == c[k[2:0]], "R4 serial pixel bit", int'(pix_bit), int'(c[k[2:0]]));
      else       chk(pix_bit == 1'b0, "R4 stream zero after pixel", int'(pix_bit), 0);
      if (k < 11) chk(done == 1'b0, "R5 no early done", int'(done), 0);
    end
    @(negedge clk);
    chk(done == 1'b1, "R5 done after edge 11", int'(done), 1);
    held = result;
    @(negedge clk);
    chk(done == 1'b0, "R5 done single cycle", int'(done), 0);
    chk(result == held, "R10 hold with run high", int'(result), int'(held));
    if (clash) chk(pix_q == c, "R8 load ignored during pass", int'(pix_q), int'(c));
    load_en = 1'b0; run = 1'b0;
    @(negedge clk);
    chk(result == held, "R10 hold with run low", int'(result), int'(held));
  endtask

  task automatic abort_pass(input int len);
    @(negedge clk);
    run = 1'b1; nb_n = 1'b1; nb_s = 1'b1; nb_e = 1'b1; nb_w = 1'b1;
    for (int k = 0; k < len; k++) @(negedge clk);
    run = 1'b0; nb_n = 1'b0; nb_s = 1'b0; nb_e = 1'b0; nb_w = 1'b0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0, "R9 aborted pass gives no done", int'(done), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    int unsigned x;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(result == '0, "R1 reset result", int'(result), 0);
    chk(pix_q == '0, "R1 reset pixel", int'(pix_q), 0);
    chk(pix_bit == 1'b0, "R1 reset stream", int'(pix_bit), 0);
    chk(done == 1'b0, "R1 reset done", int'(done), 0);

    // R3 directed patterns
    run_pass(8'd0,   8'd0,   8'd0,   8'd0,   8'd0,   1'b0);
    run_pass(8'd255, 8'd0,   8'd0,   8'd0,   8'd0,   1'b0);
    run_pass(8'd0,   8'd255, 8'd255, 8'd255, 8'd255, 1'b0);
    run_pass(8'd255, 8'd255, 8'd255, 8'd255, 8'd255, 1'b0);
    run_pass(8'd10,  8'd1,   8'd1,   8'd1,   8'd0,   1'b0);
    run_pass(8'd100, 8'd7,   8'd200, 8'd33,  8'd151, 1'b1);

    // R9: abort mid-pass, then an exact pass
    abort_pass(5);
    run_pass(8'd1, 8'd3, 8'd3, 8'd3, 8'd3, 1'b0);
    abort_pass(11);
    run_pass(8'd128, 8'd129, 8'd127, 8'd64, 8'd192, 1'b1);

    x = 32'h1234_5678;
    for (int i = 0; i < 16; i++) begin
      logic [7:0] v [5];
      for (int j = 0; j < 5; j++) begin
        x = x * 32'd1103515245 + 32'd12345;
        v[j] = x[23:16];
      end
      run_pass(v[0], v[1], v[2], v[3], v[4], (i % 4) == 0);
    end

    repeat (4) @(negedge clk);
    chk(sb.size() == 0, "R5 every pass produced one done", sb.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule